// File: doc/BRIEF.md
# DMA Channel Completion and Interrupt Reporter

This block sits beside the data-movement engines of a multi-channel DMA controller and turns their completion events into software-visible state. Every channel receives a completion pulse from its engine. The pulse says whether the transfer finished normally, failed, or was aborted by a flush. The channel keeps up to two such results in a small queue. While anything is queued, the channel raises an "available" flag in its status register and sets its bit in a shared interrupt status word. Software consumes a result by reading the result register, which returns the oldest entry as a word with separate valid, error, flushed and done flags.

A single register port serves all channels. The port selects a channel and one of six registers. Writes set the two per-channel configuration enables (interrupt and flush reporting), request a flush, or load a command pointer. Loading a command pointer starts the channel. Flush and start requests leave the block as one-cycle pulses toward the engine. A single interrupt line combines the pending channels that have their interrupt enabled. When a channel's queue is full, the block stalls that engine's completion with a ready signal instead of losing it.

Top module: `dma_result_reporter`

## Requirements
- R1: After reset no channel holds a result, the interrupt status word and `irq_o` are 0, every `evt_ready_o` bit is 1, and no flush or start pulse is driven.
- R2: A completion kind is given on two bits: 0 = done, 1 = error, 2 = flushed, 3 = error. A held result reads as a word with bit 31 (valid) set and exactly one flag set: bit 1 for done, bit 3 for error, bit 2 for flushed. All other bits are 0.
- R3: While channel i holds at least one result, its status register (select 3) reads with bit 1 set and the interrupt status register (select 5) has bit i set. Otherwise both bits are 0.
- R4: A read strobe on the result register (select 1) returns the oldest result of the chosen channel and removes it. The status and interrupt bits stay set if another result remains queued. A result read on an empty channel returns 0 and changes nothing.
- R5: Each channel queues two results in arrival order. While its queue is full, `evt_ready_o` for that channel is 0 and a presented completion is held. It is accepted on the first edge after a slot frees.
- R6: `irq_o` is 1 exactly when some channel has its interrupt status bit set and its interrupt enable (configuration bit 0) set.
- R7: When a channel's flush-reporting enable (configuration bit 1) is 0, flushed completions are accepted and discarded. Done and error completions are still queued.
- R8: A write of 0 to the flush register (select 2) drives that channel's `flush_req_o` bit high for exactly the next cycle. A write of any nonzero value there produces no pulse.
- R9: A write to the command pointer register (select 0) stores the value, which reads back from select 0, and drives that channel's `start_o` bit high for exactly the next cycle.
- R10: The configuration register (select 4) stores write data bits 1:0 and reads them back in bits 1:0, with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | NUM_CH | Completion event presented, one bit per channel |
| evt_kind_i | input | 2*NUM_CH | Completion kind, two bits per channel |
| evt_ready_o | output | NUM_CH | Channel can accept a completion |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (consumes on result reads) |
| reg_sel_i | input | 3 | Register select |
| reg_ch_i | input | CH_W | Channel select |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for current select, combinational |
| flush_req_o | output | NUM_CH | One-cycle flush request to the engine |
| start_o | output | NUM_CH | One-cycle start request to the engine |
| cmd_ptr_o | output | NUM_CH*DATA_W | Stored command pointer per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with NUM_CH = 4 and DEPTH = 2 and keeps DATA_W at 32. Four channels are few enough to sweep every channel against every completion kind under full enables, and to check the exact interrupt status value for each one. A two-deep queue lets a third completion back-pressure after two events, so the stall, the release after a pop, and the arrival order can all be observed through the ports. Four channels also make two-channel cases tractable: events arriving on the same cycle, and interrupt masking on one channel while another stays pending.

// File: rtl/drr_pkg.sv
package drr_pkg;
  typedef enum logic [2:0] {
    SEL_CMD_PTR  = 3'd0,
    SEL_RESULT   = 3'd1,
    SEL_FLUSH    = 3'd2,
    SEL_STATUS   = 3'd3,
    SEL_CONF     = 3'd4,
    SEL_IRQ_STAT = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    EVT_DONE  = 2'd0,
    EVT_ERR   = 2'd1,
    EVT_FLUSH = 2'd2,
    EVT_ERR2  = 2'd3
  } evt_kind_e;

  localparam int unsigned RES_VALID_BIT  = 31;
  localparam int unsigned RES_ERR_BIT    = 3;
  localparam int unsigned RES_FLUSH_BIT  = 2;
  localparam int unsigned RES_DONE_BIT   = 1;
  localparam int unsigned STAT_AVAIL_BIT = 1;
  localparam int unsigned CONF_IRQ_EN    = 0;
  localparam int unsigned CONF_FLUSH_EN  = 1;

  typedef struct packed {
    logic err;
    logic flushed;
    logic done;
  } result_t;

  function automatic result_t kind_to_result(logic [1:0] kind);
    result_t r;
    r = '0;
    unique case (kind)
      EVT_DONE:  r.done    = 1'b1;
      EVT_FLUSH: r.flushed = 1'b1;
      default:   r.err     = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/drr_result_queue.sv
module drr_result_queue #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned W     = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];

  function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= wrap_inc(wr_q);
      end
      if (do_pop) rd_q <= wrap_inc(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/drr_channel.sv
module drr_channel
  import drr_pkg::*;
#(
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  input  logic [1:0]        evt_kind_i,
  output logic              evt_ready_o,
  input  logic              wr_i,
  input  logic              rd_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic              pending_o,
  output logic [1:0]        conf_o,
  output logic [DATA_W-1:0] cmd_ptr_o,
  output logic              start_o,
  output logic              flush_req_o
);
  logic [1:0]        conf_q;
  logic [DATA_W-1:0] ptr_q;
  logic              start_q, flush_q;
  result_t           head, incoming;
  logic              full, empty, push, pop;

  assign incoming = kind_to_result(evt_kind_i);
  assign evt_ready_o = !full;
  // flushed results are dropped when flush reporting is off
  assign push = evt_valid_i && !full && !(incoming.flushed && !conf_q[CONF_FLUSH_EN]);
  assign pop  = rd_i && (sel_i == SEL_RESULT) && !empty;

  drr_result_queue #(.DEPTH(DEPTH), .W($bits(result_t))) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (incoming),
    .pop_i   (pop),
    .dout_o  (head),
    .full_o  (full),
    .empty_o (empty)
  );

  always_comb begin
    result_o = '0;
    if (!empty) begin
      result_o[RES_VALID_BIT] = 1'b1;
      result_o[RES_ERR_BIT]   = head.err;
      result_o[RES_FLUSH_BIT] = head.flushed;
      result_o[RES_DONE_BIT]  = head.done;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conf_q  <= '0;
      ptr_q   <= '0;
      start_q <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      start_q <= wr_i && (sel_i == SEL_CMD_PTR);
      flush_q <= wr_i && (sel_i == SEL_FLUSH) && (wdata_i == '0);
      if (wr_i && sel_i == SEL_CONF)    conf_q <= wdata_i[1:0];
      if (wr_i && sel_i == SEL_CMD_PTR) ptr_q  <= wdata_i;
    end
  end

  assign pending_o   = !empty;
  assign conf_o      = conf_q;
  assign cmd_ptr_o   = ptr_q;
  assign start_o     = start_q;
  assign flush_req_o = flush_q;
endmodule

// File: rtl/drr_read_mux.sv
module drr_read_mux
  import drr_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CH_W   = 4
) (
  input  reg_sel_e                   sel_i,
  input  logic [CH_W-1:0]            ch_i,
  input  logic [NUM_CH*DATA_W-1:0]   result_i,
  input  logic [NUM_CH*DATA_W-1:0]   ptr_i,
  input  logic [2*NUM_CH-1:0]        conf_i,
  input  logic [NUM_CH-1:0]          pending_i,
  output logic [DATA_W-1:0]          rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_CMD_PTR:  rdata_o = ptr_i[ch_i*DATA_W +: DATA_W];
      SEL_RESULT:   rdata_o = result_i[ch_i*DATA_W +: DATA_W];
      SEL_STATUS:   rdata_o[STAT_AVAIL_BIT] = pending_i[ch_i];
      SEL_CONF:     rdata_o[1:0] = conf_i[ch_i*2 +: 2];
      SEL_IRQ_STAT: rdata_o = DATA_W'(pending_i);
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_result_reporter.sv
module dma_result_reporter
  import drr_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH-1:0]          evt_valid_i,
  input  logic [2*NUM_CH-1:0]        evt_kind_i,
  output logic [NUM_CH-1:0]          evt_ready_o,
  input  logic                       reg_wr_i,
  input  logic                       reg_rd_i,
  input  logic [2:0]                 reg_sel_i,
  input  logic [CH_W-1:0]            reg_ch_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  output logic [NUM_CH-1:0]          flush_req_o,
  output logic [NUM_CH-1:0]          start_o,
  output logic [NUM_CH*DATA_W-1:0]   cmd_ptr_o,
  output logic                       irq_o
);
  reg_sel_e                  sel;
  logic [NUM_CH*DATA_W-1:0]  result_flat;
  logic [2*NUM_CH-1:0]       conf_flat;
  logic [NUM_CH-1:0]         irq_stat;
  logic [NUM_CH-1:0]         irq_en;

  assign sel = reg_sel_e'(reg_sel_i);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = (reg_ch_i == CH_W'(g));

    drr_channel #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .evt_valid_i (evt_valid_i[g]),
      .evt_kind_i  (evt_kind_i[2*g +: 2]),
      .evt_ready_o (evt_ready_o[g]),
      .wr_i        (reg_wr_i && hit),
      .rd_i        (reg_rd_i && hit),
      .sel_i       (sel),
      .wdata_i     (reg_wdata_i),
      .result_o    (result_flat[g*DATA_W +: DATA_W]),
      .pending_o   (irq_stat[g]),
      .conf_o      (conf_flat[2*g +: 2]),
      .cmd_ptr_o   (cmd_ptr_o[g*DATA_W +: DATA_W]),
      .start_o     (start_o[g]),
      .flush_req_o (flush_req_o[g])
    );
    assign irq_en[g] = conf_flat[2*g + CONF_IRQ_EN];
  end

  drr_read_mux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_mux (
    .sel_i     (sel),
    .ch_i      (reg_ch_i),
    .result_i  (result_flat),
    .ptr_i     (cmd_ptr_o),
    .conf_i    (conf_flat),
    .pending_i (irq_stat),
    .rdata_o   (reg_rdata_o)
  );

  assign irq_o = |(irq_stat & irq_en);
endmodule

// File: rtl/dma_result_reporter_chk.sv
module dma_result_reporter_chk #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] evt_valid_i,
  input logic [NUM_CH-1:0] evt_ready_o,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [2:0]        reg_sel_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [NUM_CH-1:0] flush_req_o,
  input logic [NUM_CH-1:0] start_o,
  input logic [NUM_CH-1:0] irq_stat,
  input logic              irq_o
);
  assert_start_from_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o != '0) |-> $past(reg_wr_i && reg_sel_i == 3'd0));

  assert_start_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o));

  assert_flush_from_zero_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_req_o != '0) |-> $past(reg_wr_i && reg_sel_i == 3'd2 && reg_wdata_i == '0));

  assert_flush_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flush_req_o));

  assert_irq_needs_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_stat != '0));

  assert_stat_set_by_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_stat & ~$past(irq_stat)) != '0) |-> $past((evt_valid_i & evt_ready_o) != '0));

  assert_stat_clear_by_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(irq_stat) & ~irq_stat) != '0) |-> $past(reg_rd_i && reg_sel_i == 3'd1));
endmodule

bind dma_result_reporter dma_result_reporter_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_i (evt_valid_i),
  .evt_ready_o (evt_ready_o),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .flush_req_o (flush_req_o),
  .start_o     (start_o),
  .irq_stat    (irq_stat),
  .irq_o       (irq_o)
);

// File: tb/dma_result_reporter_test.sv
`timescale 1ns/1ps
module dma_result_reporter_test;
  localparam int NCH = 4;
  localparam int DW  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  evt_valid = '0;
  logic [2*NCH-1:0] evt_kind = '0;
  logic [NCH-1:0]  evt_ready;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]      reg_sel = '0;
  logic [1:0]      reg_ch = '0;
  logic [DW-1:0]   reg_wdata = '0;
  logic [DW-1:0]   rdata;
  logic [NCH-1:0]  flush_req, start;
  logic [NCH*DW-1:0] cmd_ptr;
  logic            irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_result_reporter #(.NUM_CH(NCH), .DEPTH(2), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(evt_valid), .evt_kind_i(evt_kind),
    .evt_ready_o(evt_ready), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_sel_i(reg_sel),
    .reg_ch_i(reg_ch), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata),
    .flush_req_o(flush_req), .start_o(start), .cmd_ptr_o(cmd_ptr), .irq_o(irq)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_word(int kind);
    return 32'h8000_0000 | ((kind == 0) ? 32'h2 : (kind == 2) ? 32'h4 : 32'h8);
  endfunction

  task automatic post(int ch, int kind);
    @(negedge clk);
    evt_valid[ch] = 1'b1;
    evt_kind[2*ch +: 2] = 2'(kind);
    @(negedge clk);
    evt_valid[ch] = 1'b0;
  endtask

  task automatic wr(int ch, int sel, logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_ch = 2'(ch); reg_sel = 3'(sel); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int ch, int sel, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_ch = 2'(ch); reg_sel = 3'(sel);
    #1 d = rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(int ch, int sel, output logic [DW-1:0] d);
    reg_rd = 1'b0; reg_ch = 2'(ch); reg_sel = 3'(sel);
    #1 d = rdata;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", DW'(evt_ready), 32'hF);
    chk("R1 irq", DW'(irq), 0);
    chk("R1 pulses", DW'({flush_req, start}), 0);
    peek(0, 5, d); chk("R1 irq_stat", d, 0);
    for (int c = 0; c < NCH; c++) begin
      peek(c, 1, d); chk("R1 result empty", d, 0);
    end

    // R2 R3 R4 sweep every channel x kind, enables on
    for (int c = 0; c < NCH; c++) begin
      wr(c, 4, 32'h3);
      peek(c, 4, d); chk("R10 conf readback", d, 32'h3);
      for (int k = 0; k < 4; k++) begin
        post(c, k);
        peek(c, 3, d); chk("R3 status avail", d, 32'h2);
        peek(c, 5, d); chk("R3 irq_stat bit", d, DW'(1 << c));
        chk("R6 irq on", DW'(irq), 1);
        rd(c, 1, d); chk("R2 result word", d, exp_word(k));
        peek(c, 3, d); chk("R4 status cleared", d, 0);
        peek(c, 5, d); chk("R4 irq_stat cleared", d, 0);
        chk("R6 irq off", DW'(irq), 0);
      end
    end

    // R5 depth and back-pressure on channel 1
    post(1, 0);
    post(1, 1);
    chk("R5 full not ready", DW'(evt_ready[1]), 0);
    @(negedge clk);
    evt_valid[1] = 1'b1; evt_kind[3:2] = 2'd2;
    @(negedge clk);
    chk("R5 held not ready", DW'(evt_ready[1]), 0);
    rd(1, 1, d); chk("R5 first order", d, exp_word(0));
    chk("R5 ready after pop", DW'(evt_ready[1]), 1);
    peek(1, 5, d); chk("R4 irq_stat kept while queued", d, 32'h2);
    @(negedge clk);
    evt_valid[1] = 1'b0;
    rd(1, 1, d); chk("R5 second order", d, exp_word(1));
    rd(1, 1, d); chk("R5 held event delivered", d, exp_word(2));
    rd(1, 1, d); chk("R4 empty read", d, 0);
    peek(1, 3, d); chk("R4 empty status", d, 0);

    // R6 interrupt enable clear on channel 2
    wr(2, 4, 32'h2);
    post(2, 0);
    peek(2, 5, d); chk("R6 stat without enable", d, 32'h4);
    chk("R6 masked irq", DW'(irq), 0);
    rd(2, 1, d); chk("R2 masked result", d, exp_word(0));

    // R7 flush reporting disabled on channel 0
    wr(0, 4, 32'h1);
    peek(0, 4, d); chk("R10 conf readback", d, 32'h1);
    post(0, 2);
    peek(0, 3, d); chk("R7 flush dropped status", d, 0);
    peek(0, 5, d); chk("R7 flush dropped irq_stat", d, 0);
    chk("R7 ready after drop", DW'(evt_ready[0]), 1);
    post(0, 0);
    peek(0, 3, d); chk("R7 done still queued", d, 32'h2);
    rd(0, 1, d); chk("R7 done word", d, exp_word(0));

    // R8 flush request pulses
    wr(3, 2, 32'h0);
    chk("R8 flush pulse", DW'(flush_req), 32'h8);
    @(negedge clk);
    chk("R8 flush one cycle", DW'(flush_req), 0);
    wr(3, 2, 32'h5);
    chk("R8 nonzero ignored", DW'(flush_req), 0);
    @(negedge clk);
    chk("R8 nonzero ignored later", DW'(flush_req), 0);

    // R9 command pointer and start
    wr(2, 0, 32'h1234_5678);
    chk("R9 start pulse", DW'(start), 32'h4);
    peek(2, 0, d); chk("R9 ptr readback", d, 32'h1234_5678);
    chk("R9 ptr port", cmd_ptr[2*DW +: DW], 32'h1234_5678);
    @(negedge clk);
    chk("R9 start one cycle", DW'(start), 0);

    // R3 R6 two channels at once
    wr(3, 4, 32'h3);
    @(negedge clk);
    evt_valid = 4'b1001; evt_kind = '0;
    @(negedge clk);
    evt_valid = '0;
    peek(0, 5, d); chk("R3 two channels", d, 32'h9);
    wr(0, 4, 32'h0);
    chk("R6 ch3 alone", DW'(irq), 1);
    rd(3, 1, d); chk("R2 ch3 word", d, exp_word(0));
    chk("R6 ch0 masked", DW'(irq), 0);
    peek(0, 5, d); chk("R4 only ch0 left", d, 32'h1);
    rd(0, 1, d); chk("R2 ch0 word", d, exp_word(0));
    peek(0, 5, d); chk("R4 all clear", d, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule